// File: doc/BRIEF.md
# Two-Dimensional Pixel Transfer Control Unit

This block holds the control word of a two-dimensional pixel transfer engine and runs the start handshake with the transfer datapath. Software sets the run bit to begin a transfer. The block then spends one validation cycle on the stored operating mode and on the datapath's status lines. After that it either enables the datapath or drops the request. Hardware clears the run bit on completion, on an acknowledged abort or on a transfer error. Suspend and abort requests exist only while a transfer is running.

Six event flags are collected in a flag register. A separate write-one-to-clear register clears them. Each flag is gated by its own enable from the control word, and the gated flags are merged into a single interrupt line. The operating mode and the offset-unit bit are frozen while a transfer is active, so the datapath always sees a stable setup.

Top module: `pix2d_ctrl_regs`

## Requirements
- R1: After reset, the control word, the flag register, `irq`, `xfer_go` and `xfer_abort` are all 0.
- R2: There are three offsets: control word at 0, flags at 1 and flag-clear at 2. The control word has run at bit 0, suspend at bit 1, abort at bit 2, offset units at bit 6, six enables at bits 8 to 13 and mode at bits 16 to 18. Every other bit reads 0.
- R3: Writing run=1 while idle makes run read 1 at once. After one validation cycle, `xfer_go` goes high and `xfer_mode` carries the stored mode.
- R4: A `dp_done` pulse during a running transfer clears run and sets flag bit 1 (complete).
- R5: A `dp_xfer_err` pulse during a running transfer clears run and sets flag bit 0 (error). In the same cycle it takes precedence over `dp_done`, and the complete flag stays 0.
- R6: A written abort drives `xfer_abort`. When `dp_abort_ack` arrives, run clears and the complete flag is not set, even if `dp_done` arrives in the same cycle.
- R7: Suspend and abort read 0 and stay 0 whenever run is 0, including when they are written without run.
- R8: While suspend is 1, `xfer_go` is low. It returns high when suspend is written back to 0.
- R9: Writes to the mode field and the offset-unit bit are ignored while run is 1.
- R10: Mode values 6 and 7 are reserved. Launching with one of them sets flag bit 5 (configuration error) and clears run after the validation cycle. `xfer_go` never rises.
- R11: If `dp_lut_busy` is high in the validation cycle, run clears, no flag is set and `xfer_go` never rises.
- R12: The flag register holds, in bits 0 to 5: error, complete, watermark, lookup access error, lookup load done and configuration error. Writing 1 at the clear offset clears a flag. A set in the same cycle wins over the clear.
- R13: `irq` is the OR of each flag ANDed with the enable at control bit 8 plus the flag's index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register offset |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr` |
| xfer_go | output | 1 | Datapath may advance |
| xfer_abort | output | 1 | Abort request to datapath |
| xfer_mode | output | 3 | Operating mode |
| xfer_lom | output | 1 | Line offsets in bytes (1) or pixels (0) |
| dp_done | input | 1 | Transfer finished |
| dp_abort_ack | input | 1 | Datapath has stopped after an abort |
| dp_xfer_err | input | 1 | Bus error during transfer |
| dp_cfg_err | input | 1 | Datapath rejects the setup |
| dp_lut_busy | input | 1 | Lookup table load in progress |
| dp_watermark | input | 1 | Line watermark reached |
| dp_lut_acc_err | input | 1 | Lookup table access error |
| dp_lut_done | input | 1 | Lookup table load finished |
| irq | output | 1 | Merged interrupt |

## Verification
Two events can land on one edge: an abort acknowledgement together with completion, and a transfer error together with completion. The bench raises both inputs in one cycle while running. It then judges by run clearing and by which of the error and complete flags is set. It also pulses an event in the same cycle as a write-one-clear of that flag and expects the flag to survive.

// File: rtl/pix2d_ctrl_pkg.sv
package pix2d_ctrl_pkg;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_CHECK = 2'd1,
      PH_RUN   = 2'd2
   } phase_t;

   localparam int MODE_W      = 3;
   localparam int N_EVT       = 6;
   localparam int BIT_RUN     = 0;
   localparam int BIT_SUSP    = 1;
   localparam int BIT_ABORT   = 2;
   localparam int BIT_LOM     = 6;
   localparam int BIT_IEN_LO  = 8;
   localparam int BIT_MODE_LO = 16;
   localparam int CTRL_MSB    = BIT_MODE_LO + MODE_W - 1;

   localparam int EV_TE  = 0;
   localparam int EV_TC  = 1;
   localparam int EV_TW  = 2;
   localparam int EV_CAE = 3;
   localparam int EV_CTC = 4;
   localparam int EV_CE  = 5;

   localparam logic [MODE_W-1:0] MODE_LAST_VALID = 3'd5;

   function automatic logic mode_reserved(input logic [MODE_W-1:0] m);
      return m > MODE_LAST_VALID;
   endfunction

endpackage

// File: rtl/pix2d_launch_fsm.sv
module pix2d_launch_fsm
   import pix2d_ctrl_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic launch_req,
   input  logic ctrl_wr,
   input  logic susp_val,
   input  logic abort_set,
   input  logic mode_bad,
   input  logic dp_cfg_err,
   input  logic dp_lut_busy,
   input  logic dp_done,
   input  logic dp_xfer_err,
   input  logic dp_abort_ack,
   output logic start_q,
   output logic susp_q,
   output logic abort_q,
   output logic xfer_go,
   output logic ev_tc,
   output logic ev_te,
   output logic ev_ce
);

   phase_t phase_q, phase_nxt;
   logic   start_nxt, susp_nxt, abort_nxt;

   always_comb begin
      phase_nxt = phase_q;
      ev_tc     = 1'b0;
      ev_te     = 1'b0;
      ev_ce     = 1'b0;
      unique case (phase_q)
         PH_IDLE: begin
            if (launch_req) phase_nxt = PH_CHECK;
         end
         PH_CHECK: begin
            if (mode_bad || dp_cfg_err) begin
               phase_nxt = PH_IDLE;
               ev_ce     = 1'b1;
            end else if (dp_lut_busy) begin
               phase_nxt = PH_IDLE;
            end else begin
               phase_nxt = PH_RUN;
            end
         end
         PH_RUN: begin
            if (dp_xfer_err) begin
               phase_nxt = PH_IDLE;
               ev_te     = 1'b1;
            end else if (abort_q && dp_abort_ack) begin
               phase_nxt = PH_IDLE;
            end else if (dp_done) begin
               phase_nxt = PH_IDLE;
               ev_tc     = 1'b1;
            end
         end
         default: phase_nxt = PH_IDLE;
      endcase
   end

   assign start_nxt = (phase_nxt != PH_IDLE);
   assign susp_nxt  = start_nxt & (ctrl_wr ? susp_val : susp_q);
   assign abort_nxt = start_nxt & (abort_q | abort_set);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         susp_q  <= 1'b0;
         abort_q <= 1'b0;
      end else begin
         phase_q <= phase_nxt;
         susp_q  <= susp_nxt;
         abort_q <= abort_nxt;
      end
   end

   assign start_q = (phase_q != PH_IDLE);
   assign xfer_go = (phase_q == PH_RUN) & ~susp_q;

endmodule

// File: rtl/pix2d_event_flags.sv
module pix2d_event_flags #(
   parameter int N       = 6,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] ev_set,
   input  logic         clr_wr,
   input  logic [N-1:0] clr_mask,
   input  logic [N-1:0] ien,
   output logic [N-1:0] flag_q,
   output logic         irq
);

   if (N < 1) begin : g_bad_n
      $error("pix2d_event_flags: N must be at least 1");
   end

   logic [N-1:0] gated;

   for (genvar i = 0; i < N; i++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                      flag_q[i] <= 1'b0;
         else if (ev_set[i])              flag_q[i] <= 1'b1;
         else if (clr_wr && clr_mask[i])  flag_q[i] <= 1'b0;
      end
      assign gated[i] = flag_q[i] & ien[i];
   end

   if (IRQ_REG) begin : g_irq_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq <= 1'b0;
         else        irq <= |gated;
      end
   end else begin : g_irq_comb
      assign irq = |gated;
   end

endmodule

// File: rtl/pix2d_ctrl_regs.sv
module pix2d_ctrl_regs
   import pix2d_ctrl_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 4,
   parameter int CTRL_OFS = 0,
   parameter int FLAG_OFS = 1,
   parameter int FCLR_OFS = 2,
   parameter bit IRQ_REG  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              xfer_go,
   output logic              xfer_abort,
   output logic [2:0]        xfer_mode,
   output logic              xfer_lom,
   input  logic              dp_done,
   input  logic              dp_abort_ack,
   input  logic              dp_xfer_err,
   input  logic              dp_cfg_err,
   input  logic              dp_lut_busy,
   input  logic              dp_watermark,
   input  logic              dp_lut_acc_err,
   input  logic              dp_lut_done,
   output logic              irq
);

   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_OFS);
   localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(FLAG_OFS);
   localparam logic [ADDR_W-1:0] A_FCLR = ADDR_W'(FCLR_OFS);

   if (DATA_W <= CTRL_MSB) begin : g_bad_w
      $error("pix2d_ctrl_regs: DATA_W too narrow for control word");
   end
   if (CTRL_OFS == FLAG_OFS || CTRL_OFS == FCLR_OFS || FLAG_OFS == FCLR_OFS) begin : g_bad_ofs
      $error("pix2d_ctrl_regs: register offsets must differ");
   end

   logic              ctrl_wr, fclr_wr;
   logic              start_q, susp_q, abort_q;
   logic              ev_tc, ev_te, ev_ce;
   logic              lom_q;
   logic [MODE_W-1:0] mode_q;
   logic [N_EVT-1:0]  ien_q;
   logic [N_EVT-1:0]  flag_q;
   logic [N_EVT-1:0]  ev_set;
   logic              unused_wdata;

   assign ctrl_wr = reg_wr && (reg_addr == A_CTRL);
   assign fclr_wr = reg_wr && (reg_addr == A_FCLR);
   assign unused_wdata = ^reg_wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lom_q  <= 1'b0;
         mode_q <= '0;
         ien_q  <= '0;
      end else if (ctrl_wr) begin
         ien_q <= reg_wdata[BIT_IEN_LO +: N_EVT];
         if (!start_q) begin
            lom_q  <= reg_wdata[BIT_LOM];
            mode_q <= reg_wdata[BIT_MODE_LO +: MODE_W];
         end
      end
   end

   pix2d_launch_fsm u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .launch_req   (ctrl_wr & reg_wdata[BIT_RUN]),
      .ctrl_wr      (ctrl_wr),
      .susp_val     (reg_wdata[BIT_SUSP]),
      .abort_set    (ctrl_wr & reg_wdata[BIT_ABORT]),
      .mode_bad     (mode_reserved(mode_q)),
      .dp_cfg_err   (dp_cfg_err),
      .dp_lut_busy  (dp_lut_busy),
      .dp_done      (dp_done),
      .dp_xfer_err  (dp_xfer_err),
      .dp_abort_ack (dp_abort_ack),
      .start_q      (start_q),
      .susp_q       (susp_q),
      .abort_q      (abort_q),
      .xfer_go      (xfer_go),
      .ev_tc        (ev_tc),
      .ev_te        (ev_te),
      .ev_ce        (ev_ce)
   );

   always_comb begin
      ev_set         = '0;
      ev_set[EV_TE]  = ev_te;
      ev_set[EV_TC]  = ev_tc;
      ev_set[EV_TW]  = dp_watermark;
      ev_set[EV_CAE] = dp_lut_acc_err;
      ev_set[EV_CTC] = dp_lut_done;
      ev_set[EV_CE]  = ev_ce;
   end

   pix2d_event_flags #(
      .N       (N_EVT),
      .IRQ_REG (IRQ_REG)
   ) u_flags (
      .clk      (clk),
      .rst_n    (rst_n),
      .ev_set   (ev_set),
      .clr_wr   (fclr_wr),
      .clr_mask (reg_wdata[N_EVT-1:0]),
      .ien      (ien_q),
      .flag_q   (flag_q),
      .irq      (irq)
   );

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == A_CTRL) begin
         reg_rdata[BIT_RUN]                = start_q;
         reg_rdata[BIT_SUSP]               = susp_q;
         reg_rdata[BIT_ABORT]              = abort_q;
         reg_rdata[BIT_LOM]                = lom_q;
         reg_rdata[BIT_IEN_LO +: N_EVT]    = ien_q;
         reg_rdata[BIT_MODE_LO +: MODE_W]  = mode_q;
      end else if (reg_addr == A_FLAG) begin
         reg_rdata[N_EVT-1:0] = flag_q;
      end
   end

   assign xfer_abort = abort_q;
   assign xfer_mode  = mode_q;
   assign xfer_lom   = lom_q;

endmodule

// File: rtl/pix2d_ctrl_chk.sv
module pix2d_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       start_q,
   input logic       susp_q,
   input logic       abort_q,
   input logic       xfer_go,
   input logic [2:0] xfer_mode,
   input logic [5:0] flag_q,
   input logic       dp_done,
   input logic       dp_abort_ack,
   input logic       dp_xfer_err
);

   AST_GO_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_go |-> start_q); // R3
   AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      !start_q |-> (!susp_q && !abort_q)); // R7
   AST_SUSP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      susp_q |-> !xfer_go); // R8
   AST_MODE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (start_q && $past(start_q)) |-> $stable(xfer_mode)); // R9
   AST_RSVD_NO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(start_q) && xfer_mode > 3'd5) |=> (!start_q && !xfer_go)); // R10
   AST_TC_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q[1]) |-> $past(dp_done)); // R4
   AST_ABORT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      (start_q && $past(start_q) && abort_q && dp_abort_ack) |=> !start_q); // R6
   AST_ERR_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      (start_q && $past(start_q) && dp_xfer_err) |=> !start_q); // R5

endmodule

bind pix2d_ctrl_regs pix2d_ctrl_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .start_q      (start_q),
   .susp_q       (susp_q),
   .abort_q      (abort_q),
   .xfer_go      (xfer_go),
   .xfer_mode    (xfer_mode),
   .flag_q       (flag_q),
   .dp_done      (dp_done),
   .dp_abort_ack (dp_abort_ack),
   .dp_xfer_err  (dp_xfer_err)
);

// File: tb/pix2d_ctrl_regs_tb_top.sv
module pix2d_ctrl_regs_tb_top;

   localparam int DW = 32;
   localparam int AW = 4;
   localparam logic [AW-1:0] A_CTRL = 4'd0;
   localparam logic [AW-1:0] A_FLAG = 4'd1;
   localparam logic [AW-1:0] A_FCLR = 4'd2;
   localparam int NVEC = 5;
   localparam logic [63:0] VEC [NVEC] = '{
      {32'h0006_3F40, 32'h0006_3F40},
      {32'hFFFF_FFFE, 32'h0007_3F40},
      {32'h0005_0A00, 32'h0005_0A00},
      {32'h0000_0006, 32'h0000_0000},
      {32'h0001_0140, 32'h0001_0140}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_wr = 1'b0;
   logic [AW-1:0] reg_addr = '0;
   logic [DW-1:0] reg_wdata = '0;
   logic [DW-1:0] reg_rdata;
   logic          xfer_go, xfer_abort, xfer_lom, irq;
   logic [2:0]    xfer_mode;
   logic dp_done = 0, dp_abort_ack = 0, dp_xfer_err = 0, dp_cfg_err = 0;
   logic dp_lut_busy = 0, dp_watermark = 0, dp_lut_acc_err = 0, dp_lut_done = 0;

   int checks = 0;
   int errors = 0;
   int beats  = 0;

   always #4 clk = ~clk;

   // datapath stub: counts beats while enabled
   always @(posedge clk) if (xfer_go) beats <= beats + 1;

   pix2d_ctrl_regs dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xfer_go(xfer_go),
      .xfer_abort(xfer_abort), .xfer_mode(xfer_mode), .xfer_lom(xfer_lom),
      .dp_done(dp_done), .dp_abort_ack(dp_abort_ack), .dp_xfer_err(dp_xfer_err),
      .dp_cfg_err(dp_cfg_err), .dp_lut_busy(dp_lut_busy),
      .dp_watermark(dp_watermark), .dp_lut_acc_err(dp_lut_acc_err),
      .dp_lut_done(dp_lut_done), .irq(irq)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = '0;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   function automatic logic [31:0] ctl(input bit run, input bit susp, input bit abrt,
                                       input bit lom, input logic [5:0] ien,
                                       input logic [2:0] mode);
      return {13'd0, mode, 2'd0, ien, 1'b0, lom, 3'd0, abrt, susp, run};
   endfunction

   initial begin
      #(8 * 200000);
      errors++;
      $display("FAIL watchdog: actual hang expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] v;
      int b0;
      repeat (3) tick();
      // R1 reset state
      rd(A_CTRL, v); check("R1 ctrl", v, 0);
      rd(A_FLAG, v); check("R1 flags", v, 0);
      check("R1 irq/go/abort", {29'd0, irq, xfer_go, xfer_abort}, 0);
      rst_n = 1'b1;
      tick();

      // R2 / R7 table of layout vectors (run bit always 0)
      for (int i = 0; i < NVEC; i++) begin
         wr(A_CTRL, VEC[i][63:32]);
         rd(A_CTRL, v);
         check(i == 3 ? "R7 idle susp/abort" : "R2 layout", v, VEC[i][31:0]);
      end
      wr(A_CTRL, 0);

      // R3 launch, R9 lock, R4 completion
      wr(A_CTRL, ctl(1, 0, 0, 0, 6'h00, 3'd2));
      rd(A_CTRL, v); check("R3 run reads 1", v[0], 1);
      check("R3 go low in validation", xfer_go, 0);
      tick();
      check("R3 go high", xfer_go, 1);
      check("R3 mode out", xfer_mode, 2);
      wr(A_CTRL, ctl(1, 0, 0, 1, 6'h00, 3'd5));
      check("R9 mode locked", xfer_mode, 2);
      check("R9 lom locked", xfer_lom, 0);
      dp_done = 1; tick(); dp_done = 0;
      rd(A_CTRL, v); check("R4 run cleared", v[0], 0);
      rd(A_FLAG, v); check("R4 complete flag", v, 32'h02);
      check("R13 irq masked", irq, 0);

      // R13 interrupt enable, R12 clear
      wr(A_CTRL, ctl(0, 0, 0, 0, 6'h02, 3'd0));
      check("R13 irq enabled", irq, 1);
      wr(A_FCLR, 32'h02);
      rd(A_FLAG, v); check("R12 cleared", v, 0);
      check("R13 irq after clear", irq, 0);

      // R10 reserved mode
      wr(A_CTRL, ctl(1, 0, 0, 0, 6'h20, 3'd7));
      rd(A_CTRL, v); check("R10 run during validation", v[0], 1);
      check("R10 go low", xfer_go, 0);
      tick();
      rd(A_CTRL, v); check("R10 run cleared", v[0], 0);
      check("R10 go never", xfer_go, 0);
      rd(A_FLAG, v); check("R10 config flag", v, 32'h20);
      check("R13 irq config", irq, 1);
      wr(A_FCLR, 32'h3F);

      // R11 lookup busy
      dp_lut_busy = 1;
      wr(A_CTRL, ctl(1, 0, 0, 0, 6'h3F, 3'd0));
      tick();
      dp_lut_busy = 0;
      rd(A_CTRL, v); check("R11 run cleared", v[0], 0);
      check("R11 go never", xfer_go, 0);
      rd(A_FLAG, v); check("R11 no flag", v, 0);

      // R8 suspend
      wr(A_CTRL, ctl(1, 0, 0, 0, 6'h00, 3'd1));
      tick();
      check("R8 running", xfer_go, 1);
      wr(A_CTRL, ctl(1, 1, 0, 0, 6'h00, 3'd1));
      check("R8 go low", xfer_go, 0);
      rd(A_CTRL, v); check("R8 susp reads 1", v[1], 1);
      b0 = beats;
      repeat (5) tick();
      check("R8 position held", beats, b0);
      wr(A_CTRL, ctl(1, 0, 0, 0, 6'h00, 3'd1));
      check("R8 resumed", xfer_go, 1);
      tick();
      check("R8 advancing", beats > b0, 1);

      // R6 abort with simultaneous done
      wr(A_CTRL, ctl(1, 0, 1, 0, 6'h00, 3'd1));
      check("R6 abort out", xfer_abort, 1);
      dp_abort_ack = 1; dp_done = 1; tick(); dp_abort_ack = 0; dp_done = 0;
      rd(A_CTRL, v); check("R6 run/susp/abort cleared", v[2:0], 0);
      rd(A_FLAG, v); check("R6 no complete flag", v, 0);
      check("R7 abort out low", xfer_abort, 0);

      // R5 error with simultaneous done
      wr(A_CTRL, ctl(1, 0, 0, 0, 6'h00, 3'd0));
      tick();
      dp_xfer_err = 1; dp_done = 1; tick(); dp_xfer_err = 0; dp_done = 0;
      rd(A_CTRL, v); check("R5 run cleared", v[0], 0);
      rd(A_FLAG, v); check("R5 error only", v, 32'h01);
      wr(A_FCLR, 32'h3F);

      // R12 set wins over clear, other flag positions
      @(negedge clk);
      reg_wr = 1; reg_addr = A_FCLR; reg_wdata = 32'h04; dp_watermark = 1;
      @(negedge clk);
      reg_wr = 0; reg_wdata = 0; dp_watermark = 0;
      rd(A_FLAG, v); check("R12 set beats clear", v, 32'h04);
      dp_lut_acc_err = 1; tick(); dp_lut_acc_err = 0;
      dp_lut_done = 1; tick(); dp_lut_done = 0;
      rd(A_FLAG, v); check("R12 lookup flags", v, 32'h1C);
      wr(A_CTRL, ctl(0, 0, 0, 0, 6'h10, 3'd0));
      check("R13 irq lookup done", irq, 1);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule